// File: doc/BRIEF.md
# Eight-bit Accumulator ALU with Per-Operation Flag Masking

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle with `in_valid` high it takes an operation code, the accumulator value, a second byte operand, a bit selector, a pair of 16-bit operands for the register-pair add, and the current four flags (zero, subtract, half-carry, carry). One clock later it presents the result, a result write strobe and the next flag set. Register-file access and instruction decode stay with the surrounding core.

Each operation owns a write mask over the four flags. A flag outside the mask keeps the value it had on `flags_in`. This lets one datapath serve operations that touch all flags, only some of them, or none. The same core also carries two rotate families that differ only in their zero rule. Operations that compute flags but must not write a register, such as compare and bit test, drive the write strobe low.

Flag vector layout, used by every port and requirement: bit 3 = Z (zero), bit 2 = N (subtract), bit 1 = H (half-carry), bit 0 = C (carry).

Top module: `byte_alu`

## Requirements
- R1: While `rst` is high the outputs clear to `out_valid`=0, `result`=0, `result_we`=0 and `flags_out`=0. An operation issued with `in_valid` high appears on the outputs after the next rising edge with `out_valid`=1. A cycle without `in_valid` gives `out_valid`=0.
- R2: ADD (op 0), ADC (op 1), SUB (op 2) and SBC (op 3) compute `opa`±`opb`. ADC and SBC also use the incoming C as the carry or borrow. All four write the result and all four flags. Z is set for a zero result, N=1 only for the subtractions, H is the carry out of bit 3 or the borrow into bit 4, and C is the carry out of bit 7 or the borrow.
- R3: CP (op 7) sets the flags exactly as SUB would, with `result_we`=0.
- R4: INC (op 8) and DEC (op 9) add or subtract 1 from `opa` and set Z, N and H as for ADD/SUB. They leave C unchanged.
- R5: AND (op 4) gives Z from the result, with N=0, H=1 and C=0. OR (op 5) and XOR (op 6) give Z from the result, with N, H and C all 0.
- R6: The accumulator rotates work as follows: RLCA (op 10) rotates left circularly, RLA (op 11) rotates left through C, RRCA (op 12) rotates right circularly, and RRA (op 13) rotates right through C. Each one forces Z=0, clears N and H, and loads C with the bit shifted out.
- R7: The prefixed rotates and shifts are RLC 14, RL 15, RRC 16, RR 17, SLA 18, SRA 19 and SRL 20. Each sets Z from the result, clears N and H, and loads C with the bit shifted out. SRA keeps bit 7, and SLA and SRL shift in 0.
- R8: SWAP (op 21) exchanges the two nibbles of `opa`. It sets Z from the result and clears N, H and C.
- R9: BIT (op 22) sets Z to the inverse of `opa[bit_sel]`, with N=0 and H=1. It keeps C and has `result_we`=0. SET (op 23) and RES (op 24) force `opa[bit_sel]` to 1 or 0 and leave all flags unchanged.
- R10: DAA (op 25) applies a decimal correction to `opa`. If N=0 it adds 0x06 when H is set or the low digit is above 9, and adds 0x60 (setting C) when C is set or the value is above 0x99. If N=1 it subtracts 0x06 when H is set and 0x60 when C is set. Z comes from the result and H clears. N is unchanged.
- R11: CPL (op 26) writes the bitwise inverse of `opa` and sets N=1 and H=1. Z and C are unchanged.
- R12: SCF (op 27) sets C, and CCF (op 28) inverts C. Both clear N and H, keep Z, and have `result_we`=0.
- R13: ADDW (op 29) writes `wide_a`+`wide_b` to all 16 bits of `result`. It keeps Z and clears N. H is the carry out of bit 11 and C is the carry out of bit 15. For byte operations the upper byte of `result` is 0.
- R14: Op codes 30 and 31 change no flag and give `result_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| bit_sel | input | 3 | Bit index for BIT, SET and RES |
| opa | input | 8 | Accumulator or single operand |
| opb | input | 8 | Second byte operand |
| wide_a | input | 16 | First register-pair operand |
| wide_b | input | 16 | Second register-pair operand |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Registered result valid |
| result | output | 16 | Result, upper byte used only by ADDW |
| result_we | output | 1 | Result should be written back |
| flags_out | output | 4 | Next flags {Z,N,H,C} |

## Verification
The bench builds the block at its default width of 8 bits. At this width the 16-bit pair add and its bit-11 half-carry are reached, as are the 0x99 decimal threshold and the eight bit positions of the selector. Directed operand values sit on the flag edges: nibble carries and borrows, wrap to zero, and through-carry rotates with carry in set and clear. The incoming flag values are chosen so that every masked flag can be seen to hold its old value and not only to take its computed one.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int OP_W = 5;
  localparam int FLAG_W = 4;
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_CP   = 5'd7,
    OP_INC  = 5'd8,  OP_DEC  = 5'd9,
    OP_RLCA = 5'd10, OP_RLA  = 5'd11, OP_RRCA = 5'd12, OP_RRA  = 5'd13,
    OP_RLC  = 5'd14, OP_RL   = 5'd15, OP_RRC  = 5'd16, OP_RR   = 5'd17,
    OP_SLA  = 5'd18, OP_SRA  = 5'd19, OP_SRL  = 5'd20, OP_SWAP = 5'd21,
    OP_BIT  = 5'd22, OP_SET  = 5'd23, OP_RES  = 5'd24,
    OP_DAA  = 5'd25, OP_CPL  = 5'd26, OP_SCF  = 5'd27, OP_CCF  = 5'd28,
    OP_ADDW = 5'd29, OP_RSV0 = 5'd30, OP_RSV1 = 5'd31
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         hout
);
  localparam int LW = HB + 1;
  localparam int FW = W + 1;

  logic [LW-1:0] lo;
  logic [FW-1:0] full;

  always_comb begin
    if (sub) begin
      lo   = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]} - LW'(cin);
      full = {1'b0, a} - {1'b0, b} - FW'(cin);
    end else begin
      lo   = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + LW'(cin);
      full = {1'b0, a} + {1'b0, b} + FW'(cin);
    end
    sum  = full[W-1:0];
    cout = full[W];
    hout = lo[HB];
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e              op,
  input  logic [W-1:0]         a,
  input  logic                 cin,
  input  logic [$clog2(W)-1:0] bit_sel,
  output logic [W-1:0]         res,
  output logic                 cout,
  output logic                 bit_val
);
  localparam int NIB = W / 2;

  logic [W-1:0] one_hot;

  always_comb begin
    one_hot = W'(1) << bit_sel;
    bit_val = a[bit_sel];
    res     = a;
    cout    = 1'b0;
    case (op)
      OP_RLCA, OP_RLC: begin res = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
      OP_RLA,  OP_RL:  begin res = {a[W-2:0], cin};    cout = a[W-1]; end
      OP_RRCA, OP_RRC: begin res = {a[0], a[W-1:1]};   cout = a[0];   end
      OP_RRA,  OP_RR:  begin res = {cin, a[W-1:1]};    cout = a[0];   end
      OP_SLA:          begin res = {a[W-2:0], 1'b0};   cout = a[W-1]; end
      OP_SRA:          begin res = {a[W-1], a[W-1:1]}; cout = a[0];   end
      OP_SRL:          begin res = {1'b0, a[W-1:1]};   cout = a[0];   end
      OP_SWAP:         res = {a[NIB-1:0], a[W-1:NIB]};
      OP_SET:          res = a | one_hot;
      OP_RES:          res = a & ~one_hot;
      default:         res = a;
    endcase
  end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         n,
  input  logic         h,
  input  logic         c,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int NIB = W / 2;
  localparam logic [NIB-1:0] NINE = NIB'(9);
  localparam logic [W-1:0]   LO6  = W'(6);
  localparam logic [W-1:0]   HI6  = W'(6) << NIB;

  logic [W-1:0] adj;
  logic lo_big, hi_big;

  always_comb begin
    adj    = '0;
    cout   = c;
    lo_big = a[NIB-1:0] > NINE;
    hi_big = (a[W-1:NIB] > NINE) || ((a[W-1:NIB] == NINE) && lo_big);
    if (!n) begin
      if (c || hi_big) begin
        adj  = adj | HI6;
        cout = 1'b1;
      end
      if (h || lo_big) adj = adj | LO6;
      res = a + adj;
    end else begin
      if (c) adj = adj | HI6;
      if (h) adj = adj | LO6;
      res = a - adj;
    end
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [OP_W-1:0]           op,
  input  logic [$clog2(DATA_W)-1:0] bit_sel,
  input  logic [DATA_W-1:0]         opa,
  input  logic [DATA_W-1:0]         opb,
  input  logic [2*DATA_W-1:0]       wide_a,
  input  logic [2*DATA_W-1:0]       wide_b,
  input  logic [FLAG_W-1:0]         flags_in,
  output logic                      out_valid,
  output logic [2*DATA_W-1:0]       result,
  output logic                      result_we,
  output logic [FLAG_W-1:0]         flags_out
);
  localparam int NIB    = DATA_W / 2;
  localparam int WIDE_W = 2 * DATA_W;

  alu_op_e opc;
  assign opc = alu_op_e'(op);

  logic              c_in;
  logic              is_sub, use_cin;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] s8, sh_r, da_r, r8;
  logic [WIDE_W-1:0] s16, r_nxt;
  logic              c8, h8, c16, h16, sh_c, sh_b, da_c, z8, we_nxt;
  logic [FLAG_W-1:0] mask, fval, f_nxt;

  assign c_in = flags_in[FC];

  always_comb begin
    is_sub  = opc inside {OP_SUB, OP_SBC, OP_CP, OP_DEC};
    use_cin = opc inside {OP_ADC, OP_SBC};
    b_sel   = (opc inside {OP_INC, OP_DEC}) ? DATA_W'(1) : opb;
  end

  alu_addsub #(.W(DATA_W), .HB(NIB)) u_add8 (
    .a(opa), .b(b_sel), .cin(use_cin & c_in), .sub(is_sub),
    .sum(s8), .cout(c8), .hout(h8)
  );

  alu_addsub #(.W(WIDE_W), .HB(WIDE_W - NIB)) u_add16 (
    .a(wide_a), .b(wide_b), .cin(1'b0), .sub(1'b0),
    .sum(s16), .cout(c16), .hout(h16)
  );

  alu_shift #(.W(DATA_W)) u_shift (
    .op(opc), .a(opa), .cin(c_in), .bit_sel(bit_sel),
    .res(sh_r), .cout(sh_c), .bit_val(sh_b)
  );

  alu_decadj #(.W(DATA_W)) u_daa (
    .a(opa), .n(flags_in[FN]), .h(flags_in[FH]), .c(c_in),
    .res(da_r), .cout(da_c)
  );

  // Result selection and write strobe
  always_comb begin
    r8     = opa;
    we_nxt = 1'b0;
    case (opc)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: begin r8 = s8; we_nxt = 1'b1; end
      OP_CP:  r8 = s8;
      OP_AND: begin r8 = opa & opb; we_nxt = 1'b1; end
      OP_OR:  begin r8 = opa | opb; we_nxt = 1'b1; end
      OP_XOR: begin r8 = opa ^ opb; we_nxt = 1'b1; end
      OP_RLCA, OP_RLA, OP_RRCA, OP_RRA, OP_RLC, OP_RL, OP_RRC, OP_RR,
      OP_SLA, OP_SRA, OP_SRL, OP_SWAP, OP_SET, OP_RES: begin
        r8 = sh_r; we_nxt = 1'b1;
      end
      OP_DAA:  begin r8 = da_r; we_nxt = 1'b1; end
      OP_CPL:  begin r8 = ~opa; we_nxt = 1'b1; end
      OP_ADDW: we_nxt = 1'b1;
      default: we_nxt = 1'b0;
    endcase
    z8    = (r8 == '0);
    r_nxt = (opc == OP_ADDW) ? s16 : WIDE_W'(r8);
  end

  // Flag values and per-operation write mask, order {Z,N,H,C}
  always_comb begin
    mask = 4'b0000;
    fval = 4'b0000;
    case (opc)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP: begin
        mask = 4'b1111; fval = {z8, is_sub, h8, c8};
      end
      OP_INC, OP_DEC: begin mask = 4'b1110; fval = {z8, is_sub, h8, 1'b0}; end
      OP_AND:         begin mask = 4'b1111; fval = {z8, 3'b010}; end
      OP_OR, OP_XOR:  begin mask = 4'b1111; fval = {z8, 3'b000}; end
      OP_RLCA, OP_RLA, OP_RRCA, OP_RRA: begin
        mask = 4'b1111; fval = {3'b000, sh_c};
      end
      OP_RLC, OP_RL, OP_RRC, OP_RR, OP_SLA, OP_SRA, OP_SRL: begin
        mask = 4'b1111; fval = {z8, 2'b00, sh_c};
      end
      OP_SWAP: begin mask = 4'b1111; fval = {z8, 3'b000}; end
      OP_BIT:  begin mask = 4'b1110; fval = {~sh_b, 3'b010}; end
      OP_DAA:  begin mask = 4'b1011; fval = {z8, 2'b00, da_c}; end
      OP_CPL:  begin mask = 4'b0110; fval = 4'b0110; end
      OP_SCF:  begin mask = 4'b0111; fval = 4'b0001; end
      OP_CCF:  begin mask = 4'b0111; fval = {3'b000, ~c_in}; end
      OP_ADDW: begin mask = 4'b0111; fval = {2'b00, h16, c16}; end
      default: begin mask = 4'b0000; fval = 4'b0000; end
    endcase
    f_nxt = (flags_in & ~mask) | (fval & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      result_we <= 1'b0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= r_nxt;
        result_we <= we_nxt;
        flags_out <= f_nxt;
      end
    end
  end

  // R1
  idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && opc == OP_CP |=> out_valid && !result_we);

  // R4
  incdec_carry_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (opc == OP_INC || opc == OP_DEC) |=> flags_out[FC] == $past(flags_in[FC]));

  // R6
  accrot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (opc inside {OP_RLCA, OP_RLA, OP_RRCA, OP_RRA}) |=> !flags_out[FZ]);

  // R7
  sra_msb_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && opc == OP_SRA |=> result[DATA_W-1] == $past(opa[DATA_W-1]));

  // R9
  setres_flags_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (opc == OP_SET || opc == OP_RES) |=> flags_out == $past(flags_in));

  // R10
  daa_sub_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && opc == OP_DAA |=> flags_out[FN] == $past(flags_in[FN]));

  // R11
  cpl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && opc == OP_CPL |=> flags_out[FN] && flags_out[FH]
      && flags_out[FZ] == $past(flags_in[FZ]) && flags_out[FC] == $past(flags_in[FC]));

  // R13
  wide_zero_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && opc == OP_ADDW |=> flags_out[FZ] == $past(flags_in[FZ]) && !flags_out[FN]);

  // R14
  reserved_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (opc == OP_RSV0 || opc == OP_RSV1) |=> flags_out == $past(flags_in) && !result_we);
endmodule

// File: tb/byte_alu_test.sv
module byte_alu_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  op;
  logic [2:0]  bit_sel;
  logic [7:0]  opa, opb;
  logic [15:0] wide_a, wide_b;
  logic [3:0]  flags_in;
  logic        out_valid;
  logic [15:0] result;
  logic        result_we;
  logic [3:0]  flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  byte_alu #(.DATA_W(8)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .bit_sel(bit_sel),
    .opa(opa), .opb(opb), .wide_a(wide_a), .wide_b(wide_b), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .result_we(result_we), .flags_out(flags_out)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // drive one operation at a falling edge; outputs are valid at the next falling edge
  task automatic issue(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] s, input logic [3:0] f);
    op = o; opa = a; opb = b; bit_sel = s; flags_in = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect8(input string tag, input logic [7:0] r, input logic we, input logic [3:0] f);
    chk({tag, " result"}, result, {8'h00, r});
    chk({tag, " we"}, {15'd0, result_we}, {15'd0, we});
    chk({tag, " flags"}, {12'd0, flags_out}, {12'd0, f});
  endtask

  task automatic t_reset;
    chk("R1 reset valid", {15'd0, out_valid}, 16'd0);
    chk("R1 reset result", result, 16'd0);
    chk("R1 reset we", {15'd0, result_we}, 16'd0);
    chk("R1 reset flags", {12'd0, flags_out}, 16'd0);
    issue(5'd0, 8'h01, 8'h02, 3'd0, 4'b0000);
    chk("R1 valid after op", {15'd0, out_valid}, 16'd1);
    @(negedge clk);
    chk("R1 valid after idle", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_addsub;
    issue(5'd0, 8'h0F, 8'h01, 3'd0, 4'b0000); expect8("R2 add half", 8'h10, 1'b1, 4'b0010);
    issue(5'd0, 8'hF0, 8'h10, 3'd0, 4'b0000); expect8("R2 add wrap", 8'h00, 1'b1, 4'b1001);
    issue(5'd1, 8'h0E, 8'h01, 3'd0, 4'b0001); expect8("R2 adc cin", 8'h10, 1'b1, 4'b0010);
    issue(5'd2, 8'h10, 8'h01, 3'd0, 4'b0000); expect8("R2 sub borrow4", 8'h0F, 1'b1, 4'b0110);
    issue(5'd3, 8'h00, 8'h00, 3'd0, 4'b0001); expect8("R2 sbc cin", 8'hFF, 1'b1, 4'b0111);
  endtask

  task automatic t_compare;
    issue(5'd7, 8'h42, 8'h42, 3'd0, 4'b0011);
    chk("R3 cp we", {15'd0, result_we}, 16'd0);
    chk("R3 cp flags", {12'd0, flags_out}, 16'b1100);
    issue(5'd7, 8'h00, 8'h01, 3'd0, 4'b1000);
    chk("R3 cp borrow flags", {12'd0, flags_out}, 16'b0111);
  endtask

  task automatic t_incdec;
    issue(5'd8, 8'hFF, 8'h00, 3'd0, 4'b0001); expect8("R4 inc wrap keepC", 8'h00, 1'b1, 4'b1011);
    issue(5'd9, 8'h10, 8'h00, 3'd0, 4'b0000); expect8("R4 dec half", 8'h0F, 1'b1, 4'b0110);
    issue(5'd9, 8'h01, 8'h00, 3'd0, 4'b0001); expect8("R4 dec zero keepC", 8'h00, 1'b1, 4'b1101);
  endtask

  task automatic t_logic;
    issue(5'd4, 8'hF0, 8'h0F, 3'd0, 4'b0101); expect8("R5 and", 8'h00, 1'b1, 4'b1010);
    issue(5'd5, 8'h00, 8'h00, 3'd0, 4'b0111); expect8("R5 or", 8'h00, 1'b1, 4'b1000);
    issue(5'd6, 8'hAA, 8'hFF, 3'd0, 4'b1111); expect8("R5 xor", 8'h55, 1'b1, 4'b0000);
  endtask

  task automatic t_acc_rot;
    issue(5'd10, 8'h80, 8'h00, 3'd0, 4'b0000); expect8("R6 rlca", 8'h01, 1'b1, 4'b0001);
    issue(5'd11, 8'h80, 8'h00, 3'd0, 4'b1110); expect8("R6 rla zero forced", 8'h00, 1'b1, 4'b0001);
    issue(5'd12, 8'h01, 8'h00, 3'd0, 4'b0000); expect8("R6 rrca", 8'h80, 1'b1, 4'b0001);
    issue(5'd13, 8'h01, 8'h00, 3'd0, 4'b0001); expect8("R6 rra", 8'h80, 1'b1, 4'b0001);
  endtask

  task automatic t_pref_shift;
    issue(5'd15, 8'h80, 8'h00, 3'd0, 4'b0110); expect8("R7 rl", 8'h00, 1'b1, 4'b1001);
    issue(5'd14, 8'h00, 8'h00, 3'd0, 4'b0001); expect8("R7 rlc zero", 8'h00, 1'b1, 4'b1000);
    issue(5'd17, 8'h02, 8'h00, 3'd0, 4'b0001); expect8("R7 rr", 8'h81, 1'b1, 4'b0000);
    issue(5'd18, 8'h80, 8'h00, 3'd0, 4'b0000); expect8("R7 sla", 8'h00, 1'b1, 4'b1001);
    issue(5'd19, 8'h81, 8'h00, 3'd0, 4'b0000); expect8("R7 sra", 8'hC0, 1'b1, 4'b0001);
    issue(5'd20, 8'h01, 8'h00, 3'd0, 4'b0000); expect8("R7 srl", 8'h00, 1'b1, 4'b1001);
  endtask

  task automatic t_swap;
    issue(5'd21, 8'h3C, 8'h00, 3'd0, 4'b0111); expect8("R8 swap", 8'hC3, 1'b1, 4'b0000);
    issue(5'd21, 8'h00, 8'h00, 3'd0, 4'b0000); expect8("R8 swap zero", 8'h00, 1'b1, 4'b1000);
  endtask

  task automatic t_bits;
    issue(5'd22, 8'h08, 8'h00, 3'd3, 4'b0001);
    chk("R9 bit set flags", {12'd0, flags_out}, 16'b0011);
    chk("R9 bit we", {15'd0, result_we}, 16'd0);
    issue(5'd22, 8'h08, 8'h00, 3'd4, 4'b0100);
    chk("R9 bit clear flags", {12'd0, flags_out}, 16'b1010);
    issue(5'd23, 8'h00, 8'h00, 3'd7, 4'b1010); expect8("R9 set", 8'h80, 1'b1, 4'b1010);
    issue(5'd24, 8'hFF, 8'h00, 3'd0, 4'b0101); expect8("R9 res", 8'hFE, 1'b1, 4'b0101);
  endtask

  task automatic t_daa;
    issue(5'd25, 8'h0A, 8'h00, 3'd0, 4'b0000); expect8("R10 daa low", 8'h10, 1'b1, 4'b0000);
    issue(5'd25, 8'h9A, 8'h00, 3'd0, 4'b0000); expect8("R10 daa both", 8'h00, 1'b1, 4'b1001);
    issue(5'd25, 8'h0F, 8'h00, 3'd0, 4'b0110); expect8("R10 daa sub", 8'h09, 1'b1, 4'b0100);
  endtask

  task automatic t_cpl;
    issue(5'd26, 8'h35, 8'h00, 3'd0, 4'b1001); expect8("R11 cpl keep", 8'hCA, 1'b1, 4'b1111);
    issue(5'd26, 8'hFF, 8'h00, 3'd0, 4'b0000); expect8("R11 cpl", 8'h00, 1'b1, 4'b0110);
  endtask

  task automatic t_carryops;
    issue(5'd27, 8'h00, 8'h00, 3'd0, 4'b1110);
    chk("R12 scf flags", {12'd0, flags_out}, 16'b1001);
    chk("R12 scf we", {15'd0, result_we}, 16'd0);
    issue(5'd28, 8'h00, 8'h00, 3'd0, 4'b0111);
    chk("R12 ccf clear", {12'd0, flags_out}, 16'b0000);
    issue(5'd28, 8'h00, 8'h00, 3'd0, 4'b1000);
    chk("R12 ccf set", {12'd0, flags_out}, 16'b1001);
  endtask

  task automatic t_wide;
    wide_a = 16'h0FFF; wide_b = 16'h0001;
    issue(5'd29, 8'h55, 8'h66, 3'd0, 4'b1100);
    chk("R13 addw h11 result", result, 16'h1000);
    chk("R13 addw h11 flags", {12'd0, flags_out}, 16'b1010);
    chk("R13 addw we", {15'd0, result_we}, 16'd1);
    wide_a = 16'hFFFF; wide_b = 16'h0001;
    issue(5'd29, 8'h00, 8'h00, 3'd0, 4'b0000);
    chk("R13 addw wrap result", result, 16'h0000);
    chk("R13 addw wrap flags", {12'd0, flags_out}, 16'b0011);
    wide_a = 16'h8000; wide_b = 16'h8000;
    issue(5'd29, 8'h00, 8'h00, 3'd0, 4'b1000);
    chk("R13 addw c15 flags", {12'd0, flags_out}, 16'b1001);
    issue(5'd0, 8'hFF, 8'hFF, 3'd0, 4'b0000);
    chk("R13 byte op upper zero", result, 16'h00FE);
  endtask

  task automatic t_unused;
    issue(5'd30, 8'h12, 8'h34, 3'd0, 4'b1010);
    chk("R14 op30 flags", {12'd0, flags_out}, 16'b1010);
    chk("R14 op30 we", {15'd0, result_we}, 16'd0);
    issue(5'd31, 8'h12, 8'h34, 3'd0, 4'b0101);
    chk("R14 op31 flags", {12'd0, flags_out}, 16'b0101);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = '0; bit_sel = '0; opa = '0; opb = '0;
    wide_a = '0; wide_b = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_addsub();
    t_compare();
    t_incdec();
    t_logic();
    t_acc_rot();
    t_pref_shift();
    t_swap();
    t_bits();
    t_daa();
    t_cpl();
    t_carryops();
    t_wide();
    t_unused();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule